// File: doc/BRIEF.md
# Transmit Frame Assembler with Ones'-Complement Trailer

This block builds an outgoing network frame from 16-bit words that a host writes one at a time. Stored words are kept in a local word memory in write order. When the host issues a start, the block captures the local node address and a ones'-complement checksum. It then streams a byte frame over a valid/ready interface. The frame is a constant four-byte encapsulation header, then every stored word high byte first, then the node address word, then the checksum word.

The checksum covers the stored words and the node address, but not the header. It is kept as a running sum while words are written, so a start needs no second pass over the memory. The memory holds at most 246 words. A write beyond that limit is refused. A start that would leave no room for the two trailer words is refused as well. In both cases a one-cycle overflow pulse is raised. While a frame is streaming, a busy output is high and host writes and starts are ignored. When the final byte is accepted, the stored-word count returns to zero and the done flag rises. A clear input resets the transmit side at any time.

Top module: `tx_frame_asm`

## Requirements
- R1: After `rst` or `clr_tx` is high at a clock edge, `tx_done` is 1 and `busy`, `out_valid` and `overflow` are 0 from the next cycle, and no earlier word appears in any later frame.
- R2: A write (`wr_en` high, `start` low, `busy` low) with fewer than 246 words stored is accepted, and `tx_done` is 0 in the following cycle.
- R3: A write while 246 words are stored is refused: `overflow` is 1 for exactly the next cycle, and the word appears in no frame.
- R4: A start while more than 244 words are stored is refused: `overflow` is 1 for the next cycle, `busy` stays 0, and `tx_done` is unchanged.
- R5: An accepted start produces exactly 4 + 2×(N+2) bytes for N stored words. The bytes are 0x01, 0x01, 0x00, 0x00, then each stored word in write order with bits 15:8 before bits 7:0, then `node_addr` (value at the start edge) in the same byte order. `out_last` is 1 only on the final byte.
- R6: The final two bytes carry, high byte first, the bitwise inverse of the 16-bit end-around-carry sum of all N stored words and the node address.
- R7: `busy` is 1 from the cycle after an accepted start until the cycle after the final byte's handshake. While `busy` is 1, `wr_en` and `start` have no effect and raise no `overflow`, and `out_valid` is never 1 while `busy` is 0.
- R8: In the cycle after the final byte's handshake, `tx_done` is 1 and the stored-word count is zero, so a following start sends header, address and checksum only.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` hold their values into the next cycle.
- R10: When `wr_en` and `start` are both high in an idle cycle, the start is acted on and the written word is dropped.
- R11: `clr_tx` during streaming abandons the frame: `out_valid` and `busy` are 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_tx | input | 1 | Transmit clear, same effect as reset on this block |
| wr_en | input | 1 | Word write strobe |
| wr_data | input | 16 | Word to append |
| start | input | 1 | Start-frame strobe |
| node_addr | input | 16 | Local node address appended to each frame |
| out_valid | output | 1 | Byte available |
| out_ready | input | 1 | Sink accepts the byte |
| out_data | output | 8 | Frame byte |
| out_last | output | 1 | Final byte of the frame |
| tx_done | output | 1 | No frame pending or in flight since last clear or completion |
| overflow | output | 1 | One-cycle pulse on a refused write or start |
| busy | output | 1 | Frame streaming |

## Verification
A wrong word count shows up as soon as a frame is sent. The frame length changes, the address lands at the wrong byte position, and the overflow pulse comes one write early or late. A bad running checksum can only be seen in the last two bytes of the next frame. So every frame is checked byte by byte against a queue model that sums the words afresh. A wrong done or busy flag differs from the model in the very cycle after the edge that should have moved it. The model compares these flags on every clock.

// File: rtl/tx_frame_pkg.sv
package tx_frame_pkg;
  localparam int WORD_W    = 16;
  localparam int HDR_BYTES = 4;

  // Constant encapsulation header: two ones then two zeros.
  function automatic logic [7:0] hdr_byte(input logic [1:0] idx);
    return (idx < 2'd2) ? 8'h01 : 8'h00;
  endfunction

  // 16-bit add with end-around carry.
  function automatic logic [WORD_W-1:0] ones_add(input logic [WORD_W-1:0] a,
                                                 input logic [WORD_W-1:0] b);
    logic [WORD_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[WORD_W-1:0] + {{(WORD_W-1){1'b0}}, s[WORD_W]};
  endfunction
endpackage

// File: rtl/tx_word_ram.sv
module tx_word_ram #(
  parameter int DEPTH = 246,
  parameter int DW    = 16,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rq
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rq <= mem[ra];
  end
endmodule

// File: rtl/tx_csum_acc.sv
module tx_csum_acc
  import tx_frame_pkg::*;
(
  input  logic              clk,
  input  logic              clr,
  input  logic              add_en,
  input  logic [WORD_W-1:0] add_word,
  output logic [WORD_W-1:0] acc
);
  always_ff @(posedge clk) begin
    if (clr)         acc <= '0;
    else if (add_en) acc <= ones_add(acc, add_word);
  end
endmodule

// File: rtl/tx_byte_stream.sv
module tx_byte_stream
  import tx_frame_pkg::*;
#(
  parameter int MAX_WORDS = 246,
  parameter int CW        = 8,
  parameter int AW        = 8,
  parameter int BW        = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort,
  input  logic              launch,
  input  logic              run,
  input  logic [CW-1:0]     words,
  input  logic [WORD_W-1:0] ram_q,
  input  logic [WORD_W-1:0] addr_word,
  input  logic [WORD_W-1:0] csum_word,
  input  logic              out_ready,
  output logic [AW-1:0]     rd_addr,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_last,
  output logic              frame_end
);
  localparam logic [BW-1:0] HDR = BW'(HDR_BYTES);

  logic [BW-1:0] bidx, bidx_n, total, widx, widx_n;
  logic [7:0]    nxt_byte;
  logic          load;

  assign total = HDR + (BW'(words) << 1) + BW'(4);
  assign widx  = (bidx - HDR) >> 1;
  assign load  = run && !launch && !abort && (!out_valid || out_ready) && (bidx < total);
  assign frame_end = out_valid && out_ready && out_last;

  // Byte source for the current index; even offsets carry the high byte.
  always_comb begin
    if (bidx < HDR)                 nxt_byte = hdr_byte(bidx[1:0]);
    else if (widx < BW'(words))     nxt_byte = bidx[0] ? ram_q[7:0]     : ram_q[15:8];
    else if (widx == BW'(words))    nxt_byte = bidx[0] ? addr_word[7:0] : addr_word[15:8];
    else                            nxt_byte = bidx[0] ? csum_word[7:0] : csum_word[15:8];
  end

  // Memory address follows the next index so its data is ready one cycle later.
  always_comb begin
    if (abort || launch) bidx_n = '0;
    else if (load)       bidx_n = bidx + BW'(1);
    else                 bidx_n = bidx;
    widx_n  = (bidx_n >= HDR) ? ((bidx_n - HDR) >> 1) : '0;
    rd_addr = (widx_n < BW'(MAX_WORDS)) ? AW'(widx_n) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
      bidx      <= '0;
    end else begin
      bidx <= bidx_n;
      if (launch) begin
        out_valid <= 1'b0;
      end else if (load) begin
        out_valid <= 1'b1;
        out_data  <= nxt_byte;
        out_last  <= (bidx == total - BW'(1));
      end else if (out_valid && out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tx_frame_asm.sv
module tx_frame_asm
  import tx_frame_pkg::*;
#(
  parameter int MAX_WORDS = 246
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_tx,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              start,
  input  logic [WORD_W-1:0] node_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_last,
  output logic              tx_done,
  output logic              overflow,
  output logic              busy
);
  localparam int CW = $clog2(MAX_WORDS + 1);
  localparam int AW = $clog2(MAX_WORDS);
  localparam int BW = $clog2(HDR_BYTES + 2 * (MAX_WORDS + 2) + 1);

  logic [CW-1:0]     count;
  logic [WORD_W-1:0] acc, addr_q, csum_q, ram_q;
  logic [AW-1:0]     rd_addr;
  logic              flush, idle, start_ok, start_bad, wr_ok, wr_bad, frame_end;

  assign flush     = rst || clr_tx;
  assign idle      = !busy;
  assign start_ok  = idle && start && (count <= CW'(MAX_WORDS - 2));
  assign start_bad = idle && start && (count >  CW'(MAX_WORDS - 2));
  assign wr_ok     = idle && wr_en && !start && (count <  CW'(MAX_WORDS));
  assign wr_bad    = idle && wr_en && !start && (count >= CW'(MAX_WORDS));

  always_ff @(posedge clk) begin
    if (flush) begin
      count    <= '0;
      tx_done  <= 1'b1;
      busy     <= 1'b0;
      overflow <= 1'b0;
    end else begin
      overflow <= wr_bad || start_bad;
      if (wr_ok) begin
        count   <= count + CW'(1);
        tx_done <= 1'b0;
      end
      if (start_ok) begin
        busy    <= 1'b1;
        tx_done <= 1'b0;
        addr_q  <= node_addr;
        csum_q  <= ~ones_add(acc, node_addr);
      end
      if (frame_end) begin
        busy    <= 1'b0;
        count   <= '0;
        tx_done <= 1'b1;
      end
    end
  end

  tx_word_ram #(.DEPTH(MAX_WORDS), .DW(WORD_W), .AW(AW)) u_ram (
    .clk (clk),
    .we  (wr_ok && !flush),
    .wa  (AW'(count)),
    .wd  (wr_data),
    .ra  (rd_addr),
    .rq  (ram_q)
  );

  tx_csum_acc u_csum (
    .clk      (clk),
    .clr      (flush || frame_end),
    .add_en   (wr_ok),
    .add_word (wr_data),
    .acc      (acc)
  );

  tx_byte_stream #(.MAX_WORDS(MAX_WORDS), .CW(CW), .AW(AW), .BW(BW)) u_stream (
    .clk       (clk),
    .rst       (rst),
    .abort     (clr_tx),
    .launch    (start_ok),
    .run       (busy),
    .words     (count),
    .ram_q     (ram_q),
    .addr_word (addr_q),
    .csum_word (csum_q),
    .out_ready (out_ready),
    .rd_addr   (rd_addr),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last),
    .frame_end (frame_end)
  );
endmodule

// File: rtl/tx_frame_asm_chk.sv
module tx_frame_asm_chk (
  input logic       clk,
  input logic       rst,
  input logic       clr_tx,
  input logic       wr_en,
  input logic       start,
  input logic       busy,
  input logic       tx_done,
  input logic       overflow,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_last
);
  assert_clear_state_R1: assert property (@(posedge clk) disable iff (rst)
    clr_tx |=> (tx_done && !busy && !out_valid && !overflow));

  assert_write_clears_done_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !start && !busy && !clr_tx) |=> !tx_done);

  assert_no_overflow_busy_R7: assert property (@(posedge clk) disable iff (rst)
    busy |=> !overflow);

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !out_valid);

  assert_last_done_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_last && !clr_tx) |=> (tx_done && !busy));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !clr_tx) |=>
      (out_valid && $stable(out_data) && $stable(out_last)));
endmodule

bind tx_frame_asm tx_frame_asm_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .clr_tx    (clr_tx),
  .wr_en     (wr_en),
  .start     (start),
  .busy      (busy),
  .tx_done   (tx_done),
  .overflow  (overflow),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last)
);

// File: tb/tx_frame_asm_bench.sv
module tx_frame_asm_bench;
  localparam int CAP = 246;

  logic        clk = 1'b0;
  logic        rst = 1'b1, clr_tx = 1'b0, wr_en = 1'b0, start = 1'b0, out_ready = 1'b1;
  logic [15:0] wr_data = '0, node_addr = 16'h1234;
  logic        out_valid, out_last, tx_done, overflow, busy;
  logic [7:0]  out_data;

  always #2 clk = ~clk;  // 250 MHz

  tx_frame_asm u_tx_frame_asm (
    .clk(clk), .rst(rst), .clr_tx(clr_tx), .wr_en(wr_en), .wr_data(wr_data),
    .start(start), .node_addr(node_addr), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .tx_done(tx_done), .overflow(overflow),
    .busy(busy)
  );

  int compared = 0, mismatched = 0, cycles = 0;
  bit rnd_rdy = 1'b0;

  // Reference model state (prediction for the next edge).
  int  m_words[$];
  int  m_exp[$];
  int  m_pos = 0, m_n = 0;
  bit  m_done = 1'b1, m_busy = 1'b0, m_ovf = 1'b0;
  bit  pend_hold = 1'b0;
  logic [7:0] hold_d;
  logic       hold_l;

  function automatic int csum(int ws[$], int a);
    int s = a;
    foreach (ws[i]) s += ws[i];
    while (s > 65535) s = (s & 65535) + (s >> 16);
    return (~s) & 65535;
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", what, act, exp, $time);
    end
  endtask

  // Compare at the falling edge, then advance the model with the inputs that
  // the next rising edge will see.
  always @(negedge clk) begin
    chk(tx_done == m_done, "R1/R2/R8 tx_done", tx_done, m_done);
    chk(busy == m_busy, "R7/R11 busy", busy, m_busy);
    chk(overflow == m_ovf, "R3/R4 overflow", overflow, m_ovf);
    if (!m_busy) chk(out_valid == 1'b0, "R7/R11 out_valid idle", out_valid, 0);
    if (pend_hold && m_busy) begin
      chk(out_valid && out_data == hold_d && out_last == hold_l,
          "R9 hold under backpressure", {out_valid, out_last, out_data}, {1'b1, hold_l, hold_d});
    end

    pend_hold = out_valid && !out_ready && !clr_tx && !rst;
    hold_d = out_data;
    hold_l = out_last;
    m_ovf = 1'b0;
    if (rst || clr_tx) begin
      m_words.delete(); m_exp.delete();
      m_done = 1'b1; m_busy = 1'b0;
    end else if (m_busy) begin
      if (out_valid && out_ready) begin
        if (m_exp.size() == 0) begin
          chk(1'b0, "R5 extra byte", out_data, 0);
        end else begin
          if (m_pos < 4)                chk(out_data == m_exp[0], "R5 header byte", out_data, m_exp[0]);
          else if (m_pos < 4 + 2*m_n)   chk(out_data == m_exp[0], "R5 data byte", out_data, m_exp[0]);
          else if (m_pos < 6 + 2*m_n)   chk(out_data == m_exp[0], "R5 address byte", out_data, m_exp[0]);
          else                          chk(out_data == m_exp[0], "R6 checksum byte", out_data, m_exp[0]);
          chk(out_last == (m_exp.size() == 1), "R5 out_last", out_last, m_exp.size() == 1);
          void'(m_exp.pop_front());
          m_pos++;
          if (m_exp.size() == 0) begin
            m_busy = 1'b0; m_done = 1'b1; m_words.delete();  // R8
          end
        end
      end
    end else if (start) begin  // R10: start wins over a same-cycle write
      if (m_words.size() <= CAP - 2) begin
        int c;
        c = csum(m_words, int'(node_addr));
        m_exp = '{1, 1, 0, 0};
        foreach (m_words[i]) begin
          m_exp.push_back(m_words[i] >> 8);
          m_exp.push_back(m_words[i] & 255);
        end
        m_exp.push_back(int'(node_addr) >> 8);
        m_exp.push_back(int'(node_addr) & 255);
        m_exp.push_back(c >> 8);
        m_exp.push_back(c & 255);
        m_n = m_words.size(); m_pos = 0;
        m_busy = 1'b1; m_done = 1'b0;
      end else begin
        m_ovf = 1'b1;  // R4
      end
    end else if (wr_en) begin
      if (m_words.size() < CAP) begin
        m_words.push_back(int'(wr_data)); m_done = 1'b0;
      end else begin
        m_ovf = 1'b1;  // R3
      end
    end
  end

  always @(posedge clk) begin
    #1 out_ready = rnd_rdy ? ($urandom % 3 != 0) : 1'b1;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      mismatched++; compared++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input int w);
    step(); wr_en = 1'b1; wr_data = 16'(w);
    step(); wr_en = 1'b0;
  endtask

  task automatic go();
    step(); start = 1'b1;
    step(); start = 1'b0;
  endtask

  task automatic clear();
    step(); clr_tx = 1'b1;
    step(); clr_tx = 1'b0;
  endtask

  task automatic wait_idle();
    step();
    while (m_busy) step();
    repeat (2) step();
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    // R1: reset state
    chk(tx_done && !busy && !out_valid && !overflow, "R1 reset state",
        {tx_done, busy, out_valid, overflow}, 4'b1000);

    // R2, R5, R6: small frame, sink always ready
    wr(16'h0102); wr(16'hA0B0); wr(16'h00FF);
    go(); wait_idle();

    // R8: frame with no stored words carries only address and checksum
    node_addr = 16'hFFFF;
    go(); wait_idle();

    // R6 carry folding, R9 backpressure
    rnd_rdy = 1'b1;
    node_addr = 16'h8001;
    wr(16'hFFFF); wr(16'h8000); wr(16'hFFFE); wr(16'h7FFF); wr(16'h0001);
    go();
    // R7: writes and starts during streaming are ignored
    repeat (3) begin wr(16'hDEAD); go(); end
    wait_idle();

    // R10: write and start in the same idle cycle
    wr(16'h5555);
    step(); wr_en = 1'b1; wr_data = 16'h9999; start = 1'b1;
    step(); wr_en = 1'b0; start = 1'b0;
    wait_idle();

    // R3, R4: fill to capacity, extra write and start refused
    for (int i = 0; i < CAP; i++) wr(i * 263 + 7);
    wr(16'hBEEF);
    go();
    repeat (2) step();
    clear();
    // R4: 245 words still too many
    for (int i = 0; i < CAP - 1; i++) wr(i * 131);
    go();
    repeat (2) step();
    clear();
    // Largest accepted frame: 244 words
    node_addr = 16'h0F0F;
    for (int i = 0; i < CAP - 2; i++) wr(65535 - i * 97);
    go(); wait_idle();

    // R11: clear in mid-frame, then empty frame proves nothing remains (R1)
    for (int i = 0; i < 10; i++) wr(i + 16'h4000);
    go();
    repeat (8) step();
    clear();
    go(); wait_idle();

    rnd_rdy = 1'b0;
    repeat (4) step();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule